// File: doc/BRIEF.md
# Retry-Queued Bus Admission Controller

This block decides, cycle by cycle, whether a request for a shared bus may go ahead. One requester at a time presents a request with its port number, a transfer size in bytes and a flag that marks it as an express snoop. The grant answer is combinational and comes back in the same cycle. A granted ordinary request occupies the bus for a number of cycles equal to its size divided by the bus width, rounded up. While the bus is occupied, ordinary requests are refused.

A refused port is placed at the tail of an ordered retry list. A port that is already in the list is not entered a second time. Once the bus is free and ports are waiting, the block opens a retry phase and sends a one-cycle retry pulse to the port at the head of the list. From then on, only that port can win the bus with an ordinary request. When its request is granted, the port leaves the list and the retry phase closes. The next waiting port is then called as soon as the bus is free again.

Express snoops skip all of these rules. They are granted at once, never wait in the list and leave the bus occupancy unchanged. Address decoding, data transport and response routing are handled by other blocks.

Top module: `bus_admit_ctrl`

## Requirements
- R1: An ordinary request (req_express=0) that arrives while bus_busy=1 is refused (req_grant=0), and its port is appended to the retry list.
- R2: While the retry list holds at least one port, an ordinary request is granted only when a retry phase is open and the requester is the head port. In every other case it is refused. When the list is empty and bus_busy=0, an ordinary request is granted.
- R3: A request with req_express=1 is granted in the same cycle, whatever the bus occupancy and the list contents. It does not change bus_busy, and its port is not added to the list.
- R4: An ordinary request granted with size S bytes drives bus_busy=1 for exactly ceil(S/BUS_BYTES) cycles, beginning in the cycle after the grant (BUS_BYTES=16 by default). A size of 0 leaves bus_busy at 0.
- R5: The list is served strictly in the order in which refused ports were appended.
- R6: A retry phase opens in a cycle where no phase is open, bus_busy=0 and the list is non-empty. In the following cycle retry_port carries a single-cycle pulse, where bit i set means port i is the head. The output is otherwise zero and never has more than one bit set.
- R7: Granting the head port's ordinary request removes that port from the list and closes the retry phase. If ports are still waiting, the next head is called once bus_busy=0 again.
- R8: A port that is already in the list is not appended again. The list holds at most NUM_PORTS entries.
- R9: Reset empties the list, closes the retry phase and clears bus_busy and retry_port.
- R10: req_grant is never 1 when req_valid=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A request is presented this cycle |
| req_port | input | $clog2(NUM_PORTS) | Number of the requesting port |
| req_size | input | SIZE_W | Transfer size in bytes |
| req_express | input | 1 | Request is an express snoop |
| req_grant | output | 1 | Request accepted this cycle |
| retry_port | output | NUM_PORTS | One-cycle retry pulse to the head port |
| bus_busy | output | 1 | Bus is occupied by an earlier transfer |

## Verification
The list can change at both ends in the same cycle. Two cases are provoked on purpose. In the first, a new port is refused and appended in the very cycle the bus goes idle and the retry phase opens. The pulse that follows must still name the older head, and the new port must be called last. In the second, an express snoop arrives while the bus is busy during a retry phase. The check is that it is granted with no change to the occupancy window and no change to the calling order. A scoreboard holds the expected grant, retry pulse and busy value for every cycle. The duplicate-entry case is judged by the order in which ports are called later.

// File: rtl/bus_admit_pkg.sv
package bus_admit_pkg;

  // Retry phase of the admission controller.
  typedef enum logic {
    PH_OPEN_BUS = 1'b0,
    PH_CALLING  = 1'b1
  } call_phase_e;

endpackage

// File: rtl/occupancy_timer.sv
module occupancy_timer #(
  parameter int SIZE_W    = 8,
  parameter int BUS_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SIZE_W-1:0] size,
  output logic              busy
);

  localparam int SHIFT = $clog2(BUS_BYTES);
  localparam int CNT_W = SIZE_W + 1 - SHIFT;

  logic [SIZE_W:0]  size_round;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  // ceil(size / BUS_BYTES) in bus cycles
  always_comb begin
    size_round = {1'b0, size} + (SIZE_W + 1)'(BUS_BYTES - 1);
    span       = size_round[SIZE_W:SHIFT];
  end

  always_comb begin
    cnt_n = cnt_q;
    if (load)
      cnt_n = span;
    else if (cnt_q != '0)
      cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);

  assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_load_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

endmodule

// File: rtl/retry_list.sv
module retry_list #(
  parameter int NUM_PORTS = 4,
  parameter int PID_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic [PID_W-1:0]     push_id,
  input  logic                 pop,
  output logic [PID_W-1:0]     head_id,
  output logic                 not_empty,
  output logic [NUM_PORTS-1:0] member
);

  localparam int CNT_W = $clog2(NUM_PORTS + 1);

  logic [PID_W-1:0]     slot_q [NUM_PORTS];
  logic [PID_W-1:0]     wr_q, wr_n, rd_q, rd_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic [NUM_PORTS-1:0] mem_q, mem_n;
  logic                 push_ok;

  function automatic logic [PID_W-1:0] wrap_inc(input logic [PID_W-1:0] p);
    return (p == PID_W'(NUM_PORTS - 1)) ? '0 : p + PID_W'(1);
  endfunction

  // A port already waiting is not entered twice.
  assign push_ok = push && !mem_q[push_id];

  always_comb begin
    wr_n  = push_ok ? wrap_inc(wr_q) : wr_q;
    rd_n  = pop     ? wrap_inc(rd_q) : rd_q;
    cnt_n = cnt_q + CNT_W'(push_ok) - CNT_W'(pop);
    mem_n = mem_q;
    if (pop)
      mem_n[slot_q[rd_q]] = 1'b0;
    if (push_ok)
      mem_n[push_id] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      mem_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      mem_q <= mem_n;
    end
  end

  // Slot storage needs no reset; membership and count qualify it.
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && wr_q == PID_W'(i))
        slot_q[i] <= push_id;
    end
  end

  assign head_id   = slot_q[rd_q];
  assign not_empty = (cnt_q != '0);
  assign member    = mem_q;

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |-> (cnt_q < CNT_W'(NUM_PORTS)));

  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

  assert_count_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mem_q) == int'(cnt_q));

endmodule

// File: rtl/admit_decide.sv
module admit_decide #(
  parameter int PID_W = 2
) (
  input  logic             req_valid,
  input  logic             req_express,
  input  logic [PID_W-1:0] req_port,
  input  logic             bus_busy,
  input  logic             list_nonempty,
  input  logic             calling,
  input  logic [PID_W-1:0] head_id,
  output logic             grant,
  output logic             refuse,
  output logic             pop,
  output logic             occupy
);

  logic is_head_turn;
  logic ordinary_ok;

  always_comb begin
    is_head_turn = calling && (req_port == head_id);
    ordinary_ok  = !bus_busy && (!list_nonempty || is_head_turn);
    grant        = req_valid && (req_express || ordinary_ok);
    refuse       = req_valid && !grant;
    pop          = grant && !req_express && calling;
    occupy       = grant && !req_express;
  end

endmodule

// File: rtl/bus_admit_ctrl.sv
module bus_admit_ctrl #(
  parameter int NUM_PORTS = 4,
  parameter int SIZE_W    = 8,
  parameter int BUS_BYTES = 16,
  localparam int PID_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [PID_W-1:0]     req_port,
  input  logic [SIZE_W-1:0]    req_size,
  input  logic                 req_express,
  output logic                 req_grant,
  output logic [NUM_PORTS-1:0] retry_port,
  output logic                 bus_busy
);

  import bus_admit_pkg::*;

  logic [1:0]           rst_pipe;
  logic                 rst_int_n;
  logic                 grant, refuse, pop, occupy;
  logic [PID_W-1:0]     head_id;
  logic                 list_nonempty;
  logic [NUM_PORTS-1:0] member;
  call_phase_e          phase_q, phase_n;
  logic [NUM_PORTS-1:0] retry_q, retry_n;
  logic                 open_call;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  admit_decide #(.PID_W(PID_W)) u_decide (
    .req_valid     (req_valid),
    .req_express   (req_express),
    .req_port      (req_port),
    .bus_busy      (bus_busy),
    .list_nonempty (list_nonempty),
    .calling       (phase_q == PH_CALLING),
    .head_id       (head_id),
    .grant         (grant),
    .refuse        (refuse),
    .pop           (pop),
    .occupy        (occupy)
  );

  occupancy_timer #(.SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES)) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (occupy),
    .size  (req_size),
    .busy  (bus_busy)
  );

  retry_list #(.NUM_PORTS(NUM_PORTS), .PID_W(PID_W)) u_list (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (refuse),
    .push_id   (req_port),
    .pop       (pop),
    .head_id   (head_id),
    .not_empty (list_nonempty),
    .member    (member)
  );

  always_comb begin
    open_call = (phase_q == PH_OPEN_BUS) && !bus_busy && list_nonempty;
    phase_n   = phase_q;
    if (pop)
      phase_n = PH_OPEN_BUS;
    else if (open_call)
      phase_n = PH_CALLING;
    retry_n = open_call ? ({{(NUM_PORTS-1){1'b0}}, 1'b1} << head_id) : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= PH_OPEN_BUS;
      retry_q <= '0;
    end else begin
      phase_q <= phase_n;
      retry_q <= retry_n;
    end
  end

  assign req_grant  = grant;
  assign retry_port = retry_q;

  assert_express_granted_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_express) |-> req_grant);

  assert_busy_refuses_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && !req_express && bus_busy) |-> !req_grant);

  assert_retry_onehot_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(retry_port));

  assert_retry_on_idle_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (retry_port != '0) |-> (!bus_busy && member[head_id]));

  assert_retry_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (retry_port != '0) |=> (retry_port == '0));

  assert_grant_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_grant |-> req_valid);

endmodule

// File: tb/sim_bus_admit_ctrl.sv
`timescale 1ns/100ps
module sim_bus_admit_ctrl;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_port;
  logic [7:0]    req_size;
  logic          req_express;
  logic          req_grant;
  logic [NP-1:0] retry_port;
  logic          bus_busy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic       g;
    logic [3:0] r;
    logic       b;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  bus_admit_ctrl #(.NUM_PORTS(NP), .SIZE_W(8), .BUS_BYTES(16)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_port    (req_port),
    .req_size    (req_size),
    .req_express (req_express),
    .req_grant   (req_grant),
    .retry_port  (retry_port),
    .bus_busy    (bus_busy)
  );

  task automatic check1(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0b exp=%0b", what, act, exp);
    end
  endtask

  // Monitor: compares each cycle's outputs at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check1(req_grant, e.g, {e.tag, " grant"});
      checks++;
      if (retry_port !== e.r) begin
        errors++;
        $display("FAIL %s retry: act=%b exp=%b", e.tag, retry_port, e.r);
      end
      check1(bus_busy, e.b, {e.tag, " busy"});
    end
  end

  // Driver: presents one cycle of stimulus and queues its expected outcome
  task automatic step(input logic v, input logic [1:0] p, input logic [7:0] s,
                      input logic x, input logic eg, input logic [3:0] er,
                      input logic eb, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    req_valid   = v;
    req_port    = p;
    req_size    = s;
    req_express = x;
    e.g = eg; e.r = er; e.b = eb; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drain();
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    @(negedge clk);
    #0.5;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_port = '0; req_size = '0; req_express = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check1(bus_busy, 1'b0, "R9 reset busy");
    check1(retry_port != '0, 1'b0, "R9 reset retry");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    step(1, 0, 32, 0, 1, 4'b0000, 0, "R10 grant on empty idle bus");
    step(1, 1, 16, 0, 0, 4'b0000, 1, "R1 refuse p1 busy");
    step(1, 2, 16, 0, 0, 4'b0000, 1, "R1 refuse p2 busy");
    step(1, 3,  0, 0, 0, 4'b0000, 0, "R2 refuse p3 while call opens");
    step(1, 2, 16, 0, 0, 4'b0010, 0, "R6 pulse head p1, R2 non-head");
    step(1, 1, 16, 0, 1, 4'b0000, 0, "R7 head p1 granted");
    step(1, 3, 64, 1, 1, 4'b0000, 1, "R3 express while busy");
    step(0, 0,  0, 0, 0, 4'b0000, 0, "R3 express leaves occupancy");
    step(0, 0,  0, 0, 0, 4'b0100, 0, "R5 second in order p2");
    step(1, 0, 16, 0, 0, 4'b0000, 0, "R2 non-head refused in call");
    step(1, 2,  0, 0, 1, 4'b0000, 0, "R7 head p2 granted size zero");
    step(0, 0,  0, 0, 0, 4'b0000, 0, "R4 size zero no occupancy");
    step(0, 0,  0, 0, 0, 4'b1000, 0, "R8 no duplicate p2, head p3");
    step(1, 3, 17, 0, 1, 4'b0000, 0, "R4 grant 17 bytes");
    step(0, 0,  0, 0, 0, 4'b0000, 1, "R4 first busy cycle");
    step(1, 1, 16, 1, 1, 4'b0000, 1, "R3 express second busy cycle");
    step(0, 0,  0, 0, 0, 4'b0000, 0, "R4 ceil gives two cycles");
    step(1, 0, 16, 0, 1, 4'b0001, 0, "R5 last head p0 granted on pulse");
    step(1, 1, 16, 0, 0, 4'b0000, 1, "R1 refuse p1 busy");
    step(0, 0,  0, 0, 0, 4'b0000, 0, "R7 call reopens after idle");
    step(1, 1,  0, 0, 1, 4'b0010, 0, "R7 head p1 granted");
    step(1, 2, 16, 0, 1, 4'b0000, 0, "R2 list empty idle grant");
    step(0, 0,  0, 0, 0, 4'b0000, 1, "R4 one cycle");
    step(1, 0, 48, 0, 1, 4'b0000, 0, "R10 grant before reset");
    step(1, 1, 16, 0, 0, 4'b0000, 1, "R1 refuse before reset");
    drain();

    // R9: reset in mid-operation with a waiting port and an occupied bus
    rst_n = 1'b0;
    @(negedge clk);
    check1(bus_busy, 1'b0, "R9 busy cleared");
    check1(retry_port != '0, 1'b0, "R9 retry cleared");
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(1, 2, 16, 0, 1, 4'b0000, 0, "R9 list emptied, grant");
    step(0, 0,  0, 0, 0, 4'b0000, 1, "R9 occupancy");
    step(0, 0,  0, 0, 0, 4'b0000, 0, "R9 no stale call");
    step(0, 0,  0, 0, 0, 4'b0000, 0, "R9 no stale pulse");
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule